// File: doc/BRIEF.md
# Single-Wire Sync Line Codec

This block sits between a local power-stage controller and a shared synchronization wire that several converters hold in common. The wire is an open-drain node with a pull-up, so it reads low whenever any attached device pulls it low. One device on the wire is the master and sets the line clock; every other device listens. A device is the master when all of its phase-configuration strap inputs are tied low. As master, the codec pulls the wire low at the start of every line period. The length of that low pulse carries a symbol: a frame marker, or one data bit taken from a parallel word.

On every device, the master included, a counter-based receiver watches the resolved wire level using a fast sampling clock. It measures each period from one falling edge to the next and the low time within that period. It gives the controller a recovered-clock strobe, a marker flag, data bits, a framing-error flag, the assembled word and a lock indication. No analog clock recovery is involved. All timing comes from counts of the sampling clock.

With the default parameters the sampling clock is 200 MHz and the nominal line rate is 500 kHz. That gives a nominal period of 400 sampling clocks. The accepted line band of 475 to 525 kHz maps to periods of 381 to 421 clocks. The missing-edge timeout is 842 clocks.

Top module: `synl_codec`

## Requirements
- R1: The codec is master only when every bit of `cfg_phase` is 0. As master it pulls `line_pull_low` low at the start of each 400-clock period. With any strap bit at 1 it never asserts `line_pull_low`.
- R2: A master frame is one marker period (100 clocks low) followed by `DATA_BITS` data periods. The data bits are sent least significant bit first. A 1 is sent as 200 clocks low and a 0 as 300 clocks low. Then the next frame begins.
- R3: The master samples `tx_word` in the last clock of the marker period. Changes made during the data periods take effect only in the next frame.
- R4: The receiver sees the wired level, which is `line_in` AND NOT `line_pull_low`. A master therefore decodes its own frames when the external line is held high.
- R5: A period is the count of clocks from one falling edge to the next. If it lies within 381..421 clocks inclusive, `rx_tick` pulses for one clock, 3 rising clock edges after the closing falling edge appears on `line_in`.
- R6: The received pulse is classified by comparing low*100 with period*percentage, bounds inclusive. A marker is 22..28 %, a data 1 is 45..55 % and a data 0 is 72..78 %. A marker pulses `rx_mark`. A data bit pulses `rx_bit_stb` and loads `rx_bit`. Both are flagged together with `rx_tick`.
- R7: A pulse in range whose width falls in none of the three bands pulses `rx_frame_err`. It leaves `rx_bit` unchanged and abandons any word being assembled.
- R8: A period outside 381..421 produces no `rx_tick`, no symbol flag and no error flag, and it abandons any word being assembled.
- R9: `rx_locked` rises at the fourth consecutive in-range period.
- R10: `rx_locked` falls at the second consecutive out-of-range period. A single out-of-range period between in-range periods keeps the lock.
- R11: If no falling edge arrives for 842 clocks after the last one, `rx_locked` clears and any partial word is dropped. The next falling edge only starts a new measurement and produces no `rx_tick`.
- R12: After a marker, the next `DATA_BITS` data bits are assembled least significant bit first. `rx_word` is loaded and `rx_word_vld` pulses together with the last bit's strobe. Data bits that have no marker before them are not assembled. `rx_word` changes only at such a completion.
- R13: After reset all strobes are 0, `rx_bit`, `rx_word` and `rx_locked` are 0, and a non-master drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (nominally 200 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_phase | input | PHASE_W (5) | Phase strap inputs; all zero selects master |
| tx_word | input | DATA_BITS (8) | Word sent by the master after each marker |
| line_in | input | 1 | Sensed level of the shared wire (pulled up externally) |
| line_pull_low | output | 1 | Open-drain pull-down request for the shared wire |
| rx_tick | output | 1 | Recovered-clock strobe, one per in-range period |
| rx_mark | output | 1 | Marker received strobe |
| rx_bit_stb | output | 1 | Data bit received strobe |
| rx_bit | output | 1 | Last data bit received |
| rx_frame_err | output | 1 | Pulse width outside every band |
| rx_word | output | DATA_BITS (8) | Last completely assembled word |
| rx_word_vld | output | 1 | Strobe when `rx_word` is loaded |
| rx_locked | output | 1 | Line frequency lock indication |

## Verification
Every receive result is due 3 rising edges after the bench drives the closing falling edge of a period. There are two synchronizer stages, and the third edge registers the outputs. The bench drives the wire on falling clock edges and samples all receive strobes, the held bit, the held word and the lock flag at the falling edge that follows that third rising edge. A one-cycle strobe is therefore seen in exactly its own cycle. On the master side, `line_pull_low` follows the registered phase counter one clock after the strap change. The bench records the low-run lengths and the spacing of falling edges on every falling clock edge, and compares each run with the symbol expected in that period slot.

// File: rtl/synl_pkg.sv
package synl_pkg;

    // Width used for period and low-time measurements
    localparam int unsigned MEAS_W = 16;

    // Duty acceptance bands in percent of the period, inclusive
    localparam int unsigned MARK_LO_PCT = 22;
    localparam int unsigned MARK_HI_PCT = 28;
    localparam int unsigned ONE_LO_PCT  = 45;
    localparam int unsigned ONE_HI_PCT  = 55;
    localparam int unsigned ZERO_LO_PCT = 72;
    localparam int unsigned ZERO_HI_PCT = 78;

    typedef enum logic [1:0] {
        SYM_MARK = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_ZERO = 2'd2,
        SYM_BAD  = 2'd3
    } sym_t;

    // One completed period measurement
    typedef struct packed {
        logic              ev;      // closing falling edge of a measured period
        logic              in_rng;  // period inside the accepted band
        logic [MEAS_W-1:0] per;     // period in sampling clocks
        logic [MEAS_W-1:0] low;     // low time in sampling clocks
    } meas_t;

    function automatic logic in_band(input logic [MEAS_W-1:0] low,
                                     input logic [MEAS_W-1:0] per,
                                     input int unsigned lo_pct,
                                     input int unsigned hi_pct);
        int unsigned l100;
        int unsigned p;
        l100 = 32'(low) * 100;
        p    = 32'(per);
        return (l100 >= p * lo_pct) && (l100 <= p * hi_pct);
    endfunction

    function automatic sym_t classify(input logic [MEAS_W-1:0] low,
                                      input logic [MEAS_W-1:0] per);
        if (in_band(low, per, MARK_LO_PCT, MARK_HI_PCT))
            return SYM_MARK;
        else if (in_band(low, per, ONE_LO_PCT, ONE_HI_PCT))
            return SYM_ONE;
        else if (in_band(low, per, ZERO_LO_PCT, ZERO_HI_PCT))
            return SYM_ZERO;
        else
            return SYM_BAD;
    endfunction

    // Shortest accepted period: ceiling of sample rate over fastest line rate
    function automatic int unsigned per_min(input int unsigned sample_khz,
                                            input int unsigned fast_khz);
        return (sample_khz + fast_khz - 1) / fast_khz;
    endfunction

    // Longest accepted period: floor of sample rate over slowest line rate
    function automatic int unsigned per_max(input int unsigned sample_khz,
                                            input int unsigned slow_khz);
        return sample_khz / slow_khz;
    endfunction

endpackage

// File: rtl/synl_enc.sv
module synl_enc
    import synl_pkg::*;
#(
    parameter int unsigned PERIOD    = 400,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [DATA_BITS-1:0] tx_word,
    output logic                 pull_low
);
    localparam int unsigned PH_W = $clog2(PERIOD);
    localparam int unsigned SL_W = $clog2(DATA_BITS + 1);
    localparam logic [PH_W-1:0] W_MARK = PH_W'(PERIOD / 4);
    localparam logic [PH_W-1:0] W_ONE  = PH_W'(PERIOD / 2);
    localparam logic [PH_W-1:0] W_ZERO = PH_W'((PERIOD * 3) / 4);
    localparam logic [PH_W-1:0] PH_END = PH_W'(PERIOD - 1);
    localparam logic [SL_W-1:0] SL_END = SL_W'(DATA_BITS);

    logic                 run_q;
    logic [PH_W-1:0]      ph_q;
    logic [SL_W-1:0]      slot_q;
    logic [PH_W-1:0]      width_q;
    logic [DATA_BITS-1:0] snap_q;

    logic [SL_W-1:0]      slot_nx;
    logic [SL_W-1:0]      bidx;
    logic [DATA_BITS-1:0] word_nx;
    logic                 bit_nx;
    sym_t                 sym_nx;
    logic [PH_W-1:0]      width_nx;

    always_comb begin
        slot_nx = (slot_q == SL_END) ? '0 : slot_q + 1'b1;
        // the marker period is the sampling point for the outgoing word
        word_nx = (slot_q == '0) ? tx_word : snap_q;
        bidx    = slot_nx - 1'b1;
        bit_nx  = 1'b0;
        for (int i = 0; i < int'(DATA_BITS); i++) begin
            if (bidx == SL_W'(i))
                bit_nx = word_nx[i];
        end
        if (slot_nx == '0)
            sym_nx = SYM_MARK;
        else
            sym_nx = bit_nx ? SYM_ONE : SYM_ZERO;
        case (sym_nx)
            SYM_MARK: width_nx = W_MARK;
            SYM_ONE:  width_nx = W_ONE;
            default:  width_nx = W_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_q) begin
            ph_q    <= '0;
            slot_q  <= '0;
            width_q <= W_MARK;
            snap_q  <= '0;
        end else if (ph_q == PH_END) begin
            ph_q    <= '0;
            slot_q  <= slot_nx;
            width_q <= width_nx;
            if (slot_q == '0)
                snap_q <= tx_word;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign pull_low = run_q && (ph_q < width_q);

endmodule

// File: rtl/synl_meas.sv
module synl_meas
    import synl_pkg::*;
#(
    parameter int unsigned PMIN    = 381,
    parameter int unsigned PMAX    = 421,
    parameter int unsigned TIMEOUT = 842
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line,
    output meas_t meas,
    output logic  timeout
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_TO  = CNT_W'(TIMEOUT - 1);

    logic             s1_q, s2_q, s3_q;
    logic [CNT_W-1:0] cnt_q;
    logic             have_q;
    logic [MEAS_W-1:0] low_q;
    logic             fall, rise;
    logic [MEAS_W-1:0] span;

    assign fall = s3_q && !s2_q;
    assign rise = !s3_q && s2_q;
    assign span = MEAS_W'(cnt_q) + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            s3_q   <= 1'b1;
            cnt_q  <= '0;
            have_q <= 1'b0;
            low_q  <= '0;
        end else begin
            s1_q <= line;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (fall)
                cnt_q <= '0;
            else if (cnt_q != CNT_SAT)
                cnt_q <= cnt_q + 1'b1;
            if (rise)
                low_q <= span;
            if (fall)
                have_q <= 1'b1;
            else if (timeout)
                have_q <= 1'b0;
        end
    end

    assign timeout = have_q && !fall && (cnt_q == CNT_TO);

    always_comb begin
        meas.ev     = fall && have_q;
        meas.per    = span;
        meas.low    = low_q;
        meas.in_rng = (span >= MEAS_W'(PMIN)) && (span <= MEAS_W'(PMAX));
    end

endmodule

// File: rtl/synl_rx.sv
module synl_rx
    import synl_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  meas_t                meas,
    input  logic                 timeout,
    output logic                 tick,
    output logic                 mark,
    output logic                 bit_stb,
    output logic                 bit_val,
    output logic                 ferr,
    output logic [DATA_BITS-1:0] word,
    output logic                 word_vld
);
    localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_BITS - 1);

    sym_t                 sym;
    logic                 dbit;
    logic                 coll_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] asm_q;
    logic [DATA_BITS-1:0] asm_nx;

    always_comb begin
        sym    = classify(meas.low, meas.per);
        dbit   = (sym == SYM_ONE);
        asm_nx = asm_q;
        for (int i = 0; i < int'(DATA_BITS); i++) begin
            if (idx_q == IW'(i))
                asm_nx[i] = dbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick     <= 1'b0;
            mark     <= 1'b0;
            bit_stb  <= 1'b0;
            bit_val  <= 1'b0;
            ferr     <= 1'b0;
            word     <= '0;
            word_vld <= 1'b0;
            coll_q   <= 1'b0;
            idx_q    <= '0;
            asm_q    <= '0;
        end else begin
            tick     <= 1'b0;
            mark     <= 1'b0;
            bit_stb  <= 1'b0;
            ferr     <= 1'b0;
            word_vld <= 1'b0;
            if (timeout) begin
                coll_q <= 1'b0;
            end else if (meas.ev) begin
                if (!meas.in_rng) begin
                    coll_q <= 1'b0;
                end else begin
                    tick <= 1'b1;
                    case (sym)
                        SYM_MARK: begin
                            mark   <= 1'b1;
                            coll_q <= 1'b1;
                            idx_q  <= '0;
                        end
                        SYM_ONE, SYM_ZERO: begin
                            bit_stb <= 1'b1;
                            bit_val <= dbit;
                            if (coll_q) begin
                                asm_q <= asm_nx;
                                if (idx_q == IDX_LAST) begin
                                    word     <= asm_nx;
                                    word_vld <= 1'b1;
                                    coll_q   <= 1'b0;
                                end else begin
                                    idx_q <= idx_q + 1'b1;
                                end
                            end
                        end
                        default: begin
                            ferr   <= 1'b1;
                            coll_q <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/synl_lock.sv
module synl_lock #(
    parameter int unsigned GOOD_N = 4,
    parameter int unsigned BAD_N  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic in_rng,
    input  logic timeout,
    output logic locked
);
    localparam int unsigned GW = $clog2(GOOD_N + 1);
    localparam int unsigned BW = $clog2(BAD_N + 1);

    logic [GW-1:0] good_q;
    logic [BW-1:0] bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q <= '0;
            bad_q  <= '0;
            locked <= 1'b0;
        end else if (timeout) begin
            good_q <= '0;
            bad_q  <= '0;
            locked <= 1'b0;
        end else if (ev) begin
            if (in_rng) begin
                bad_q <= '0;
                if (good_q != GW'(GOOD_N))
                    good_q <= good_q + 1'b1;
                if (good_q == GW'(GOOD_N - 1))
                    locked <= 1'b1;
            end else begin
                good_q <= '0;
                if (bad_q != BW'(BAD_N))
                    bad_q <= bad_q + 1'b1;
                if (bad_q == BW'(BAD_N - 1))
                    locked <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/synl_codec.sv
module synl_codec
    import synl_pkg::*;
#(
    parameter int unsigned SAMPLE_KHZ   = 200000,
    parameter int unsigned LINE_NOM_KHZ = 500,
    parameter int unsigned LINE_MIN_KHZ = 475,
    parameter int unsigned LINE_MAX_KHZ = 525,
    parameter int unsigned DATA_BITS    = 8,
    parameter int unsigned PHASE_W      = 5,
    parameter int unsigned LOCK_GOOD    = 4,
    parameter int unsigned LOCK_BAD     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PHASE_W-1:0]   cfg_phase,
    input  logic [DATA_BITS-1:0] tx_word,
    input  logic                 line_in,
    output logic                 line_pull_low,
    output logic                 rx_tick,
    output logic                 rx_mark,
    output logic                 rx_bit_stb,
    output logic                 rx_bit,
    output logic                 rx_frame_err,
    output logic [DATA_BITS-1:0] rx_word,
    output logic                 rx_word_vld,
    output logic                 rx_locked
);
    localparam int unsigned PERIOD  = SAMPLE_KHZ / LINE_NOM_KHZ;
    localparam int unsigned PMIN    = per_min(SAMPLE_KHZ, LINE_MAX_KHZ);
    localparam int unsigned PMAX    = per_max(SAMPLE_KHZ, LINE_MIN_KHZ);
    localparam int unsigned TIMEOUT = 2 * PMAX;

    logic  is_master;
    logic  line_sense;
    meas_t meas;
    logic  timeout;

    assign is_master  = (cfg_phase == '0);
    // wired-AND of the external level and the local pull-down
    assign line_sense = line_in && !line_pull_low;

    synl_enc #(
        .PERIOD    (PERIOD),
        .DATA_BITS (DATA_BITS)
    ) u_enc (
        .clk      (clk),
        .rst      (rst),
        .en       (is_master),
        .tx_word  (tx_word),
        .pull_low (line_pull_low)
    );

    synl_meas #(
        .PMIN    (PMIN),
        .PMAX    (PMAX),
        .TIMEOUT (TIMEOUT)
    ) u_meas (
        .clk     (clk),
        .rst     (rst),
        .line    (line_sense),
        .meas    (meas),
        .timeout (timeout)
    );

    synl_rx #(
        .DATA_BITS (DATA_BITS)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .meas     (meas),
        .timeout  (timeout),
        .tick     (rx_tick),
        .mark     (rx_mark),
        .bit_stb  (rx_bit_stb),
        .bit_val  (rx_bit),
        .ferr     (rx_frame_err),
        .word     (rx_word),
        .word_vld (rx_word_vld)
    );

    synl_lock #(
        .GOOD_N (LOCK_GOOD),
        .BAD_N  (LOCK_BAD)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .ev      (meas.ev),
        .in_rng  (meas.in_rng),
        .timeout (timeout),
        .locked  (rx_locked)
    );

endmodule

// File: rtl/synl_chk.sv
module synl_chk #(
    parameter int unsigned PHASE_W   = 5,
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PHASE_W-1:0]   cfg_phase,
    input logic                 line_pull_low,
    input logic                 rx_tick,
    input logic                 rx_mark,
    input logic                 rx_bit_stb,
    input logic                 rx_bit,
    input logic                 rx_frame_err,
    input logic [DATA_BITS-1:0] rx_word,
    input logic                 rx_word_vld,
    input logic                 rx_locked
);
    // R1
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_phase != '0) && $past(cfg_phase != '0) |-> !line_pull_low);

    // R6
    one_sym_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_mark, rx_bit_stb, rx_frame_err}));

    // R8
    sym_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_mark || rx_bit_stb || rx_frame_err) |-> rx_tick);

    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_locked) |-> rx_tick);

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_bit) |-> rx_bit_stb);

    // R12
    word_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rx_word_vld |-> rx_bit_stb);

    // R12
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> rx_word_vld);

endmodule

bind synl_codec synl_chk #(
    .PHASE_W   (PHASE_W),
    .DATA_BITS (DATA_BITS)
) u_chk (.*);

// File: tb/tb_synl_codec.sv
`timescale 1ns/1ps
module tb_synl_codec;
    localparam int DB    = 8;
    localparam int PNOM  = 400;
    localparam int PMIN  = 381;
    localparam int PMAX  = 421;
    localparam int TO    = 842;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    cfg_phase = 5'd3;
    logic [DB-1:0] tx_word = '0;
    logic          line_in = 1'b1;
    logic          line_pull_low;
    logic          rx_tick, rx_mark, rx_bit_stb, rx_bit, rx_frame_err;
    logic [DB-1:0] rx_word;
    logic          rx_word_vld, rx_locked;

    synl_codec dut (
        .clk(clk), .rst(rst), .cfg_phase(cfg_phase), .tx_word(tx_word),
        .line_in(line_in), .line_pull_low(line_pull_low),
        .rx_tick(rx_tick), .rx_mark(rx_mark), .rx_bit_stb(rx_bit_stb),
        .rx_bit(rx_bit), .rx_frame_err(rx_frame_err), .rx_word(rx_word),
        .rx_word_vld(rx_word_vld), .rx_locked(rx_locked)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state, built from the requirements
    bit          m_have = 0;
    int          m_pP = 0, m_pW = 0;
    int          m_good = 0, m_bad = 0;
    bit          m_lock = 0, m_coll = 0, m_bit = 0;
    int          m_idx = 0;
    bit [DB-1:0] m_asm = '0, m_word = '0;

    // 0 marker, 1 one, 2 zero, 3 none
    function automatic int exp_kind(input int low, input int per);
        if (low * 100 >= per * 22 && low * 100 <= per * 28) return 0;
        if (low * 100 >= per * 45 && low * 100 <= per * 55) return 1;
        if (low * 100 >= per * 72 && low * 100 <= per * 78) return 2;
        return 3;
    endfunction

    task automatic check_prev();
        bit in_r, e_mark, e_bs, e_fe, e_vld;
        int k;
        if (!m_have) begin
            // R11: first edge after reset or timeout only starts a measurement
            chk(rx_tick == 1'b0, "R11 tick", int'(rx_tick), 0);
            chk(rx_locked == m_lock, "R11 lock", int'(rx_locked), int'(m_lock));
            return;
        end
        in_r   = (m_pP >= PMIN) && (m_pP <= PMAX);
        k      = exp_kind(m_pW, m_pP);
        e_mark = in_r && (k == 0);
        e_bs   = in_r && (k == 1 || k == 2);
        e_fe   = in_r && (k == 3);
        e_vld  = 0;
        if (in_r) begin
            m_bad = 0;
            if (m_good < 4) m_good++;
            if (m_good == 4) m_lock = 1;
            if (k == 0) begin
                m_coll = 1; m_idx = 0;
            end else if (k == 3) begin
                m_coll = 0;
            end else begin
                m_bit = (k == 1);
                if (m_coll) begin
                    m_asm[m_idx] = m_bit;
                    if (m_idx == DB - 1) begin
                        m_word = m_asm; e_vld = 1; m_coll = 0;
                    end else m_idx++;
                end
            end
        end else begin
            m_good = 0;
            m_bad++;
            if (m_bad >= 2) m_lock = 0;
            m_coll = 0;
        end
        chk(rx_tick == in_r, in_r ? "R5 tick" : "R8 tick", int'(rx_tick), int'(in_r));
        chk(rx_mark == e_mark, "R6 mark", int'(rx_mark), int'(e_mark));
        chk(rx_bit_stb == e_bs, "R6 bit strobe", int'(rx_bit_stb), int'(e_bs));
        chk(rx_frame_err == e_fe, "R7 frame error", int'(rx_frame_err), int'(e_fe));
        chk(rx_bit == m_bit, "R7 held bit", int'(rx_bit), int'(m_bit));
        chk(rx_word_vld == e_vld, "R12 word valid", int'(rx_word_vld), int'(e_vld));
        chk(rx_word == m_word, "R12 word", int'(rx_word), int'(m_word));
        chk(rx_locked == m_lock, in_r ? "R9 lock" : "R10 lock", int'(rx_locked), int'(m_lock));
    endtask

    // one line period: W clocks low then P-W clocks high; results of the
    // previous period are due 3 rising edges after this falling edge
    task automatic pulse(input int P, input int W);
        @(negedge clk) line_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_prev();
        m_have = 1; m_pP = P; m_pW = W;
        repeat (W - 3) @(negedge clk);
        line_in = 1'b1;
        repeat (P - W - 1) @(negedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk) line_in = 1'b1;
        repeat (n) @(negedge clk);
        m_have = 0; m_lock = 0; m_good = 0; m_bad = 0; m_coll = 0;
        // R11
        chk(rx_locked == 1'b0, "R11 timeout unlock", int'(rx_locked), 0);
    endtask

    task automatic send_word(input bit [DB-1:0] w);
        pulse(PNOM, 100);
        for (int i = 0; i < DB; i++) pulse(PNOM, w[i] ? 200 : 300);
    endtask

    // master-side monitor
    bit mon_on = 0;
    bit prev_pl = 0;
    int run = 0, nr = 0, nf = 0, cyc = 0;
    int runs [64];
    int falls [64];

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (mon_on) begin
            if (line_pull_low) begin
                if (!prev_pl && nf < 64) begin falls[nf] = cyc; nf++; end
                run++;
            end else if (prev_pl) begin
                if (nr < 64) begin runs[nr] = run; nr++; end
                run = 0;
            end
            prev_pl = line_pull_low;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rv;
        rv = $urandom(32'd20240611);
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(rx_tick == 0 && rx_mark == 0 && rx_bit_stb == 0 && rx_frame_err == 0,
            "R13 strobes", int'({rx_tick, rx_mark, rx_bit_stb, rx_frame_err}), 0);
        chk(rx_word == 0 && rx_bit == 0, "R13 data", int'(rx_word), 0);
        chk(rx_locked == 0, "R13 lock", int'(rx_locked), 0);
        chk(line_pull_low == 0, "R13 no drive", int'(line_pull_low), 0);

        // R9 R12: a clean frame, lock builds on the fourth in-range period
        send_word(8'h5A);
        send_word(8'hC3);
        // bits with no marker before them are not assembled (R12)
        pulse(PNOM, 200); pulse(PNOM, 300);

        // R6 R7: band edges at the nominal period
        pulse(PNOM, 88);  pulse(PNOM, 112); pulse(PNOM, 87);  pulse(PNOM, 113);
        pulse(PNOM, 180); pulse(PNOM, 220); pulse(PNOM, 179); pulse(PNOM, 221);
        pulse(PNOM, 288); pulse(PNOM, 312); pulse(PNOM, 287); pulse(PNOM, 313);
        // R7: framing error in the middle of a word abandons it
        pulse(PNOM, 100); pulse(PNOM, 200); pulse(PNOM, 150); pulse(PNOM, 300);

        // R5 R8 R10: period edges, single miss keeps lock, two drop it
        pulse(PMIN, 100); pulse(PMAX, 105); pulse(PMIN - 1, 100);
        pulse(PNOM, 100); pulse(PMAX + 1, 200); pulse(PMAX + 1, 200);
        pulse(PNOM, 100); pulse(PNOM, 100); pulse(PNOM, 100); pulse(PNOM, 100);
        pulse(PNOM, 100);

        // constrained random periods and widths
        for (int n = 0; n < 130; n++) begin
            int P, W, pct, sel;
            P   = 376 + int'($urandom % 50);
            sel = int'($urandom % 8);
            case (sel)
                0:       pct = 23 + int'($urandom % 5);
                1, 2, 3: pct = 46 + int'($urandom % 9);
                4, 5, 6: pct = 73 + int'($urandom % 5);
                default: pct = 5 + int'($urandom % 91);
            endcase
            W = (P * pct) / 100;
            if (W < 5) W = 5;
            if (W > P - 5) W = P - 5;
            pulse(P, W);
        end
        send_word(8'h96);
        pulse(PNOM, 100);

        // R11: missing edge
        idle(TO + 60);
        pulse(PNOM, 100);
        pulse(PNOM, 100);
        idle(TO + 60);

        // R1 R2 R3 R4: master mode with the external line released high
        @(negedge clk);
        tx_word = 8'hA5;
        cfg_phase = 5'd0;
        mon_on = 1;
        repeat (500) @(negedge clk);
        tx_word = 8'h3C;
        repeat (6900) @(negedge clk);
        for (int k = 0; k < 18; k++) begin
            int s, ew;
            bit [DB-1:0] w;
            s = k % 9;
            w = (k < 9) ? 8'hA5 : 8'h3C;
            if (s == 0) ew = 100;
            else ew = w[s-1] ? 200 : 300;
            chk(k < nr && runs[k] == ew, (s == 0) ? "R2 marker width" : "R3 bit width",
                (k < nr) ? runs[k] : -1, ew);
        end
        for (int k = 0; k < 17; k++)
            chk(k + 1 < nf && falls[k+1] - falls[k] == PNOM, "R1 master period",
                (k + 1 < nf) ? falls[k+1] - falls[k] : -1, PNOM);
        chk(rx_word == 8'h3C, "R4 loopback word", int'(rx_word), 8'h3C);
        chk(rx_locked == 1'b1, "R4 loopback lock", int'(rx_locked), 1);

        // R1: back to a non-zero strap, no more drive
        cfg_phase = 5'd9;
        repeat (4) @(negedge clk);
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 500; i++) begin
                @(negedge clk);
                if (line_pull_low) lows++;
            end
            chk(lows == 0, "R1 slave silent", lows, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule